// File: doc/BRIEF.md
# Longest Prefix Match Route Lookup

This block is the address-resolution stage of a packet forwarding path. It keeps a small table of IPv4 routes. Each route carries a network prefix, a prefix length and an egress port number. When a 32-bit destination address is offered, every valid route is compared with it at the same time. The block then returns the egress port of the most specific route that covers the address, together with a flag that says whether any route matched.

Routes are loaded or removed one at a time through a write port. A write sets or clears a table slot, and it affects every lookup accepted after the write cycle. Lookups use a valid/ready handshake. The result is registered and appears for one cycle, one clock after the lookup is accepted. When no route covers the address, the block returns a fallback port that is supplied on an input. A route with prefix length zero covers every address, so it serves as a default route that reports a hit.

Top module: `route_lpm_lookup`

## Requirements
- R1: While `rst_n` is low, `lk_ready` and `res_valid` are 0 and every table slot is invalid. From the cycle after reset is released, `lk_ready` is 1, and a lookup made before any write reports a miss.
- R2: A route covers an address when the top `len` bits of the address equal the top `len` bits of the route prefix. The lower bits of both are ignored. A length of 0 covers every address. Any length of 32 or more compares all 32 bits.
- R3: When several valid routes cover the address, the result port comes from the covering route with the greatest prefix length, and `res_hit` is 1.
- R4: When two or more covering routes share the greatest length, the one in the lower-numbered table slot supplies the port.
- R5: When no valid route covers the address, `res_hit` is 0 and `res_port` equals the value that `dflt_port` had in the cycle the lookup was accepted.
- R6: A lookup is accepted on a rising edge where `lk_valid` and `lk_ready` are both 1. `res_valid` is 1 for exactly the one cycle after each accepted lookup and 0 after any cycle without one.
- R7: A write (`wr_en` = 1) to slot `wr_idx` with `wr_valid` = 1 stores the prefix, length and port and makes the slot valid. With `wr_valid` = 0 the write makes the slot invalid, and the slot then takes no part in any lookup.
- R8: A lookup accepted in the same cycle as a write sees the table as it was before that write. A lookup accepted in any later cycle sees the table after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W | Slot to write |
| wr_valid | input | 1 | 1 loads the route, 0 invalidates the slot |
| wr_prefix | input | 32 | Route prefix |
| wr_len | input | 6 | Prefix length in bits |
| wr_port | input | PORT_W | Egress port of the route |
| dflt_port | input | PORT_W | Port returned when no route matches |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_addr | input | 32 | Destination address to resolve |
| res_valid | output | 1 | Result valid, one cycle per accepted lookup |
| res_hit | output | 1 | At least one route matched |
| res_port | output | PORT_W | Selected egress port |

## Verification
A table write and a lookup can land on the same clock edge. The lookup must then see the table as it was before the write. The bench drives both in one cycle in three forms: a route that is added, a route that is invalidated, and a route that is overwritten with a new port. It then repeats the same address in the next cycle. The scoreboard computes the expected result for the colliding lookup from its own table model before it applies the write, and for the repeated lookup from the model after the write. A result that follows the new table too early, or the old one too late, therefore shows up as a mismatch.

// File: rtl/lpm_pkg.sv
// Package lpm_pkg
// Shared widths and the prefix-mask helper for the route lookup block.
// Assumes IPv4 addresses; a length field wide enough to hold 0..63.
package lpm_pkg;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 6;

    // Mask with the top 'len' bits set; lengths of 32 or more give all ones.
    function automatic logic [ADDR_W-1:0] len_mask(input logic [LEN_W-1:0] len);
        logic [ADDR_W-1:0] m;
        for (int i = 0; i < ADDR_W; i++) begin
            m[i] = ((ADDR_W - 1 - i) < int'(len));
        end
        return m;
    endfunction
endpackage

// File: rtl/lpm_route_store.sv
// Module lpm_route_store
// Holds the route table: one register set per slot (valid, prefix, length, port).
// Assumes one write per cycle; a write changes the slot on the clock edge,
// so compares made in the write cycle still see the old contents.
module lpm_route_store #(
    parameter int N      = 16,
    parameter int IDX_W  = 4,
    parameter int PORT_W = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic                               wr_valid,
    input  logic [lpm_pkg::ADDR_W-1:0]         wr_prefix,
    input  logic [lpm_pkg::LEN_W-1:0]          wr_len,
    input  logic [PORT_W-1:0]                  wr_port,
    output logic [N-1:0]                       ent_vld,
    output logic [N-1:0][lpm_pkg::ADDR_W-1:0]  ent_pfx,
    output logic [N-1:0][lpm_pkg::LEN_W-1:0]   ent_len,
    output logic [N-1:0][PORT_W-1:0]           ent_port
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        // Load or clear this slot when the write addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vld[g]  <= 1'b0;
                ent_pfx[g]  <= '0;
                ent_len[g]  <= '0;
                ent_port[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_vld[g]  <= wr_valid;
                ent_pfx[g]  <= wr_prefix;
                ent_len[g]  <= wr_len;
                ent_port[g] <= wr_port;
            end
        end
    end

    // R7: the addressed slot takes the requested valid state on the next cycle.
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ent_vld[$past(wr_idx)] == $past(wr_valid)));
endmodule

// File: rtl/lpm_prefix_match.sv
// Module lpm_prefix_match
// Compares one address against every slot in parallel and returns a match vector.
// Assumes the slot fields come straight from the route store (no pipelining).
module lpm_prefix_match #(
    parameter int N = 16
) (
    input  logic [lpm_pkg::ADDR_W-1:0]         addr,
    input  logic [N-1:0]                       ent_vld,
    input  logic [N-1:0][lpm_pkg::ADDR_W-1:0]  ent_pfx,
    input  logic [N-1:0][lpm_pkg::LEN_W-1:0]   ent_len,
    output logic [N-1:0]                       hit_vec
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        // Slot matches when valid and the masked address bits agree.
        assign hit_vec[g] = ent_vld[g] &&
            (((addr ^ ent_pfx[g]) & lpm_pkg::len_mask(ent_len[g])) == '0);
    end
endmodule

// File: rtl/lpm_longest_pick.sv
// Module lpm_longest_pick
// Picks the matching slot with the greatest prefix length; ties go to the lowest slot.
// Assumes a linear scan is short enough for the table size (16 by default).
module lpm_longest_pick #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]                      hit_vec,
    input  logic [N-1:0][lpm_pkg::LEN_W-1:0]  ent_len,
    output logic                              any_hit,
    output logic [IDX_W-1:0]                  win_idx
);
    logic [lpm_pkg::LEN_W-1:0] best_len;

    // Scan upward; strictly longer replaces, so equal lengths keep the lower slot.
    always_comb begin
        any_hit  = 1'b0;
        win_idx  = '0;
        best_len = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i] && (!any_hit || (ent_len[i] > best_len))) begin
                any_hit  = 1'b1;
                win_idx  = IDX_W'(i);
                best_len = ent_len[i];
            end
        end
    end
endmodule

// File: rtl/route_lpm_lookup.sv
// Module route_lpm_lookup
// Longest-prefix-match route lookup: route table, parallel compare, winner
// selection and a registered result one cycle after each accepted lookup.
// Assumes the consumer always takes the result (no result back-pressure).
module route_lpm_lookup #(
    parameter int N      = 16,
    parameter int PORT_W = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic                        wr_valid,
    input  logic [lpm_pkg::ADDR_W-1:0]  wr_prefix,
    input  logic [lpm_pkg::LEN_W-1:0]   wr_len,
    input  logic [PORT_W-1:0]           wr_port,
    input  logic [PORT_W-1:0]           dflt_port,
    input  logic                        lk_valid,
    output logic                        lk_ready,
    input  logic [lpm_pkg::ADDR_W-1:0]  lk_addr,
    output logic                        res_valid,
    output logic                        res_hit,
    output logic [PORT_W-1:0]           res_port
);
    logic [N-1:0]                       ent_vld;
    logic [N-1:0][lpm_pkg::ADDR_W-1:0]  ent_pfx;
    logic [N-1:0][lpm_pkg::LEN_W-1:0]   ent_len;
    logic [N-1:0][PORT_W-1:0]           ent_port;
    logic [N-1:0]                       hit_vec;
    logic                               any_hit;
    logic [IDX_W-1:0]                   win_idx;
    logic                               accept;

    lpm_route_store #(.N(N), .IDX_W(IDX_W), .PORT_W(PORT_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_prefix(wr_prefix), .wr_len(wr_len), .wr_port(wr_port),
        .ent_vld(ent_vld), .ent_pfx(ent_pfx), .ent_len(ent_len), .ent_port(ent_port)
    );

    lpm_prefix_match #(.N(N)) u_match (
        .addr(lk_addr), .ent_vld(ent_vld), .ent_pfx(ent_pfx),
        .ent_len(ent_len), .hit_vec(hit_vec)
    );

    lpm_longest_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .hit_vec(hit_vec), .ent_len(ent_len), .any_hit(any_hit), .win_idx(win_idx)
    );

    assign accept = lk_valid && lk_ready;

    // Ready is held low in reset and raised afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) lk_ready <= 1'b0;
        else        lk_ready <= 1'b1;
    end

    // Register the lookup result for one cycle per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_port  <= '0;
        end else begin
            res_valid <= accept;
            if (accept) begin
                res_hit  <= any_hit;
                res_port <= any_hit ? ent_port[win_idx] : dflt_port;
            end
        end
    end

    // R1: ready rises once reset is released.
    p_ready_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> lk_ready);
    // R6: each accepted lookup yields a result next cycle.
    p_result_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> res_valid);
    // R6: no result without an accepted lookup.
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !res_valid);
    // R5: a miss returns the fallback port sampled at acceptance.
    p_miss_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !any_hit) |=> (!res_hit && (res_port == $past(dflt_port))));
    // R3: the chosen slot is one that actually matches.
    p_winner_matches_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> hit_vec[win_idx]);
endmodule

// File: tb/route_lpm_lookup_bench.sv
// Scoreboard bench for route_lpm_lookup: the driver pushes expected results
// computed from its own table model; the monitor pops and compares them.
module route_lpm_lookup_bench;
    localparam int N      = 16;
    localparam int PORT_W = 4;
    localparam int IDX_W  = 4;

    typedef struct {
        logic              hit;
        logic [PORT_W-1:0] port;
        string             tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic wr_valid = 1'b0;
    logic [31:0] wr_prefix = '0;
    logic [5:0] wr_len = '0;
    logic [PORT_W-1:0] wr_port = '0;
    logic [PORT_W-1:0] dflt_port = 4'd14;
    logic lk_valid = 1'b0;
    logic lk_ready;
    logic [31:0] lk_addr = '0;
    logic res_valid;
    logic res_hit;
    logic [PORT_W-1:0] res_port;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    exp_t q[$];

    logic              m_vld [N];
    logic [31:0]       m_pfx [N];
    logic [5:0]        m_len [N];
    logic [PORT_W-1:0] m_port[N];

    always #4 clk = ~clk;

    route_lpm_lookup #(.N(N), .PORT_W(PORT_W)) u_route_lpm_lookup (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_prefix(wr_prefix), .wr_len(wr_len), .wr_port(wr_port), .dflt_port(dflt_port),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_port(res_port)
    );

    function automatic bit covers(input logic [31:0] a, input logic [31:0] p, input logic [5:0] l);
        if (l == 0) return 1'b1;
        if (l >= 32) return a == p;
        return ((a ^ p) >> (32 - int'(l))) == 0;
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // One cycle: optional write, optional lookup; expected computed before the write is modelled.
    task automatic step(input bit do_wr, input int idx, input bit vld, input logic [31:0] pfx,
                        input logic [5:0] len, input logic [PORT_W-1:0] port,
                        input bit do_lk, input logic [31:0] addr, input string tag);
        exp_t e;
        int best;
        wr_en = do_wr; wr_idx = IDX_W'(idx); wr_valid = vld;
        wr_prefix = pfx; wr_len = len; wr_port = port;
        lk_valid = do_lk; lk_addr = addr;
        if (do_lk) begin
            best = -1;
            for (int i = 0; i < N; i++)
                if (m_vld[i] && covers(addr, m_pfx[i], m_len[i]))
                    if (best < 0 || m_len[i] > m_len[best]) best = i;
            e.hit = (best >= 0);
            e.port = (best >= 0) ? m_port[best] : dflt_port;
            e.tag = tag;
            q.push_back(e);
        end
        if (do_wr) begin
            m_vld[idx] = vld; m_pfx[idx] = pfx; m_len[idx] = len; m_port[idx] = port;
        end
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [31:0] pfx, input logic [5:0] len, input logic [PORT_W-1:0] port);
        step(1, idx, 1, pfx, len, port, 0, 0, "");
    endtask

    task automatic lk(input logic [31:0] addr, input string tag);
        step(0, 0, 0, 0, 0, 0, 1, addr, tag);
    endtask

    // Monitor: compare each produced result against the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            exp_t e;
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R6 unexpected result: got valid=1 expected valid=0");
            end else begin
                e = q.pop_front();
                if (res_hit !== e.hit || res_port !== e.port) begin
                    errors++;
                    $display("FAIL %s: got hit=%0b port=%0d expected hit=%0b port=%0d",
                             e.tag, res_hit, res_port, e.hit, e.port);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_pfx[i] = 0; m_len[i] = 0; m_port[i] = 0;
        end
        // R1: reset state.
        repeat (3) @(negedge clk);
        checks++;
        if (lk_ready !== 1'b0 || res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got ready=%0b valid=%0b expected 0 0", lk_ready, res_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (lk_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 ready after reset: got %0b expected 1", lk_ready);
        end
        lk(32'h8009_100E, "R1 empty table miss");

        // Base table.
        wr(0, 32'h4100_0000, 8, 3);
        wr(1, 32'h8009_0000, 16, 1);
        wr(2, 32'h8E0C_0000, 19, 7);
        lk(32'h8009_100E, "R2 128.9.16.14 -> 1");
        lk(32'h4101_0203, "R2 65.1.2.3 -> 3");
        lk(32'h8E0C_1FFF, "R2 top of /19 -> 7");
        dflt_port = 4'd9;
        lk(32'h8E0C_2000, "R5 just past /19 miss");
        lk(32'hC0A8_0001, "R5 unrelated miss");
        dflt_port = 4'd14;

        // R6: idle cycle gives no result.
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R6 idle: got valid=%0b expected 0", res_valid);
        end

        // Overlapping routes.
        wr(4, 32'h8009_1000, 21, 2);
        wr(5, 32'h8009_B000, 24, 5);
        wr(6, 32'h8009_AC00, 21, 4);
        lk(32'h8009_100E, "R3 /21 beats /16");
        lk(32'h8009_B005, "R3 /24 beats /16");
        lk(32'h8009_AF01, "R3 172/21 range");
        lk(32'h8009_C801, "R3 only /16");
        // R4: equal-length tie, lower slot wins.
        wr(10, 32'h8009_B000, 24, 6);
        lk(32'h8009_B0FF, "R4 tie slot 5 wins");
        wr(3, 32'h8009_B000, 24, 8);
        lk(32'h8009_B0FF, "R4 tie slot 3 wins");

        // R2: /0 default route and over-long length.
        wr(15, 32'hFFFF_FFFF, 0, 12);
        lk(32'hC0A8_0001, "R2 /0 default route");
        wr(7, 32'hC801_0203, 40, 13);
        lk(32'hC801_0203, "R2 len>32 exact");
        lk(32'hC801_0202, "R2 len>32 one bit off");

        // R7: invalidate.
        step(1, 15, 0, 0, 0, 0, 0, 0, "");
        lk(32'hC0A8_0001, "R7 invalidated /0");
        step(1, 5, 0, 0, 0, 0, 0, 0, "");
        lk(32'h8009_B0FF, "R7 invalidated slot 5");

        // R8: write and lookup in the same cycle.
        step(1, 8, 1, 32'h0A00_0000, 8, 11, 1, 32'h0A01_0101, "R8 add same cycle old");
        lk(32'h0A01_0101, "R8 add next cycle new");
        step(1, 8, 0, 0, 0, 0, 1, 32'h0A01_0101, "R8 invalidate same cycle old");
        lk(32'h0A01_0101, "R8 invalidate next cycle new");
        step(1, 1, 1, 32'h8009_0000, 16, 10, 1, 32'h8009_C801, "R8 overwrite same cycle old");
        lk(32'h8009_C801, "R8 overwrite next cycle new");

        // Back-to-back lookups.
        for (int k = 0; k < 4; k++) begin
            lk(32'h4100_0000 + 32'(k), "R6 back-to-back");
        end
        repeat (3) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R6 missing results: got %0d pending expected 0", q.size());
        end
        summary();
    end
endmodule